// File: doc/BRIEF.md
# Edge-Timestamp Capture Buffer

The block stamps chosen edges of an asynchronous event input with the value of a free-running 32-bit time base. It stores the stamps in a small first-in first-out buffer that a 16-bit host reads one half at a time. The event pin passes through a two-stage synchronizer before edge detection. The stored stamp is the time-base value in the cycle the edge is detected.

Edge selection covers the rising, falling and both-edge modes. Two prescaled modes take only every fourth or every sixteenth rising edge. The host reads the low half of the oldest entry and then the high half. Only the high-half read releases the entry, so a 32-bit stamp is never torn across two entries.

Status outputs show that data is waiting and that a capture was lost. An interrupt pulse fires after a programmable number of stored captures. A capture-disable flag lets a gate source hold off capture: a gate request sets the flag, and a chosen edge of a gate signal clears it. The first qualifying event edge after that clear is captured.

Top module: `icap_fifo`

## Requirements
- R1: After reset, buf_ne, ovf, irq, cap_dis and rd_data are all 0, and the time base starts from 0, counting up by one every clock.
- R2: Mode encodings are 1 = every rising edge, 2 = every falling edge and 3 = both edges. A stored stamp equals the time-base value two clocks after the clock edge that first samples the new pin level.
- R3: Mode 4 stores only every 4th rising edge and mode 5 only every 16th rising edge. The edge count restarts from zero whenever mode is 0.
- R4: A read with rd_en=1 and rd_hi=0 puts bits 15:0 of the oldest entry on rd_data one clock later and leaves the buffer unchanged.
- R5: A read with rd_en=1 and rd_hi=1 puts bits 31:16 of the oldest entry on rd_data one clock later. The same read removes that entry if the buffer is not empty.
- R6: buf_ne is 1 exactly while at least one entry is stored.
- R7: A capture that arrives while all 4 entries are full is discarded and sets ovf. ovf then stays at 1 until a clock with ovf_clr=1 clears it.
- R8: irq pulses high for one clock after every (irq_sel+1)-th stored capture, counting from the last pulse or from a time that mode was 0.
- R9: A clock with gate_set=1 sets cap_dis one clock later. While cap_dis is 1, event edges are neither stored nor counted by the prescaler.
- R10: While cap_dis is 1, the gate edge selected by gate_pol (1 = rising, 0 = falling) clears cap_dis. The next qualifying event edge is then stored.
- R11: Mode 0 stores no captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Asynchronous event pin |
| mode | input | 3 | Edge selection mode |
| irq_sel | input | 2 | Interrupt after irq_sel+1 captures |
| gate_set | input | 1 | Gate request, sets cap_dis |
| gate_in | input | 1 | Gate signal whose edge clears cap_dis |
| gate_pol | input | 1 | Gate clearing edge: 1 rising, 0 falling |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_en | input | 1 | Read strobe |
| rd_hi | input | 1 | Read selects high half (and pops) |
| rd_data | output | 16 | Registered read data |
| buf_ne | output | 1 | Buffer not empty |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt pulse |
| cap_dis | output | 1 | Capture disable flag |

## Verification
An event-pin change driven on a falling clock edge is stored three rising edges later. The expected stamp is the bench's own count of clocks since reset plus two, and each pin step is followed by four full clocks before anything is sampled. Read data is due one clock after the strobe and is sampled on the following falling edge. The interrupt, overflow and disable flags are likewise sampled one clock after the capture, gate or clear that moves them.

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int TW    = 32,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_in,
  input  logic [2:0]  mode,
  input  logic [1:0]  irq_sel,
  input  logic        gate_set,
  input  logic        gate_in,
  input  logic        gate_pol,
  input  logic        ovf_clr,
  input  logic        rd_en,
  input  logic        rd_hi,
  output logic [15:0] rd_data,
  output logic        buf_ne,
  output logic        ovf,
  output logic        irq,
  output logic        cap_dis
);
  localparam int HW = TW / 2;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [TW-1:0] tbase;
  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [3:0]    pre_cnt;
  logic [1:0]    irq_cnt;
  logic          s1, s2, s3, g_q;
  logic          hit;

  wire rise    = s2 & ~s3;
  wire fall    = ~s2 & s3;
  wire full    = (count == CW'(DEPTH));
  wire cap     = hit & ~cap_dis;
  wire take    = cap & ~full;
  wire pop     = rd_en & rd_hi & (count != '0);
  wire g_edge  = gate_pol ? (gate_in & ~g_q) : (~gate_in & g_q);
  wire pre_mod = (mode == 3'd4) || (mode == 3'd5);

  assign buf_ne = (count != '0);

  always_comb begin
    case (mode)
      3'd1:    hit = rise;
      3'd2:    hit = fall;
      3'd3:    hit = rise | fall;
      3'd4:    hit = rise && (pre_cnt == 4'd3);
      3'd5:    hit = rise && (pre_cnt == 4'd15);
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbase <= '0;
      {s1, s2, s3, g_q} <= '0;
    end else begin
      tbase <= tbase + 1'b1;
      s1 <= evt_in;
      s2 <= s1;
      s3 <= s2;
      g_q <= gate_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (mode == 3'd0 || cap_dis)
      pre_cnt <= '0;
    else if (pre_mod && rise)
      pre_cnt <= hit ? 4'd0 : pre_cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cap_dis <= 1'b0;
    else if (gate_set)
      cap_dis <= 1'b1;
    else if (cap_dis && g_edge)
      cap_dis <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= tbase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (take) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(take) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_hi ? mem[rd_ptr][TW-1:HW] : mem[rd_ptr][HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovf <= 1'b0;
    else if (ovf_clr)
      ovf <= 1'b0;
    else if (cap && full)
      ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      irq_cnt <= '0;
    end else begin
      irq <= 1'b0;
      if (mode == 3'd0)
        irq_cnt <= '0;
      else if (take) begin
        if (irq_cnt == irq_sel) begin
          irq     <= 1'b1;
          irq_cnt <= '0;
        end else
          irq_cnt <= irq_cnt + 2'd1;
      end
    end
  end

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  assert_ovf_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(count) == CW'(DEPTH));
  assert_dis_from_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_dis) |-> $past(gate_set));
  assert_lo_read_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_hi && !take |=> $stable(count));
  assert_hi_read_pops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_hi && buf_ne && !take |=> count == $past(count) - CW'(1));
endmodule

// File: tb/icap_fifo_test.sv
module icap_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, evt_in = 0;
  logic [2:0] mode = 0;
  logic [1:0] irq_sel = 0;
  logic gate_set = 0, gate_in = 0, gate_pol = 1, ovf_clr = 0, rd_en = 0, rd_hi = 0;
  logic [15:0] rd_data;
  logic buf_ne, ovf, irq, cap_dis;

  int checks = 0, fails = 0, irq_seen = 0;
  int tbc = 0;
  logic [31:0] expq [$];
  bit done = 0;

  icap_fifo uut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .mode(mode), .irq_sel(irq_sel),
    .gate_set(gate_set), .gate_in(gate_in), .gate_pol(gate_pol), .ovf_clr(ovf_clr),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data), .buf_ne(buf_ne), .ovf(ovf),
    .irq(irq), .cap_dis(cap_dis));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tbc <= 0; else tbc <= tbc + 1;
    if (rst_n && irq) irq_seen <= irq_seen + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pin(logic v, bit store);
    @(negedge clk);
    evt_in = v;
    if (store) expq.push_back(32'(tbc + 2));
    repeat (4) @(negedge clk);
  endtask

  task automatic read_entry(string req);
    logic [15:0] lo;
    logic [31:0] exp;
    @(negedge clk); rd_en = 1; rd_hi = 0;
    @(negedge clk); lo = rd_data; rd_hi = 1;
    @(negedge clk); rd_en = 0; rd_hi = 0;
    exp = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
    chk(req, {rd_data, lo}, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 flags", {28'd0, buf_ne, ovf, irq, cap_dis}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11: mode 0 stores nothing
    pin(1, 0); pin(0, 0);
    chk("R11 buf_ne", 32'(buf_ne), 0);

    // R2 rising mode
    mode = 1;
    pin(1, 1); pin(0, 0);
    chk("R6 buf_ne set", 32'(buf_ne), 1);
    // R4: low read twice leaves entry in place
    @(negedge clk); rd_en = 1; rd_hi = 0;
    @(negedge clk); rd_en = 0;
    chk("R4 lo word", 32'(rd_data), expq[0] & 32'hFFFF);
    chk("R4 entry kept", 32'(buf_ne), 1);
    read_entry("R2 R5 rising stamp");
    chk("R6 buf_ne cleared after hi read R5", 32'(buf_ne), 0);

    // R2 falling mode
    mode = 2;
    pin(1, 0); pin(0, 1);
    read_entry("R2 falling stamp");
    chk("R2 falling only", 32'(buf_ne), 0);

    // R2 both edges
    mode = 3;
    pin(1, 1); pin(0, 1);
    read_entry("R2 both first");
    read_entry("R2 both second");

    // R3 every 4th rising
    mode = 0; @(negedge clk); mode = 4;
    for (int i = 1; i <= 8; i++) begin pin(1, (i % 4) == 0); pin(0, 0); end
    read_entry("R3 4th edge");
    read_entry("R3 8th edge");
    chk("R3 only two", 32'(buf_ne), 0);

    // R3 every 16th rising
    mode = 0; @(negedge clk); mode = 5;
    for (int i = 1; i <= 16; i++) begin
      pin(1, i == 16); pin(0, 0);
      if (i == 15) chk("R3 none before 16th", 32'(buf_ne), 0);
    end
    read_entry("R3 16th edge");

    // R8 interrupt every 3 captures
    mode = 0; irq_sel = 2; @(negedge clk); mode = 1;
    irq_seen = 0;
    pin(1, 1); pin(0, 0); pin(1, 1); pin(0, 0);
    chk("R8 no irq after 2", 32'(irq_seen), 0);
    pin(1, 1); pin(0, 0);
    chk("R8 irq after 3", 32'(irq_seen), 1);
    for (int i = 0; i < 3; i++) read_entry("R8 entries");

    // R7 overflow
    mode = 0; irq_sel = 0; @(negedge clk); mode = 1;
    for (int i = 0; i < 5; i++) begin pin(1, i < 4); pin(0, 0); end
    chk("R7 ovf set", 32'(ovf), 1);
    repeat (5) @(negedge clk);
    chk("R7 ovf sticky", 32'(ovf), 1);
    for (int i = 0; i < 4; i++) read_entry("R7 first four kept");
    chk("R7 extra discarded", 32'(buf_ne), 0);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R7 ovf cleared", 32'(ovf), 0);

    // R9 gate disable
    gate_pol = 1; gate_in = 0;
    @(negedge clk); gate_set = 1;
    @(negedge clk); gate_set = 0;
    chk("R9 cap_dis set", 32'(cap_dis), 1);
    pin(1, 0); pin(0, 0);
    chk("R9 edge ignored", 32'(buf_ne), 0);

    // R10 gate edge re-arms
    @(negedge clk); gate_in = 1;
    @(negedge clk);
    chk("R10 cap_dis cleared", 32'(cap_dis), 0);
    pin(1, 1); pin(0, 0);
    read_entry("R10 capture after re-arm");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule